// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO bus. It runs one Clause 22 frame at a time. The host sets up the controller through a control word, which holds an enable bit, a clock divider and an idle flag. It then starts a transaction with a single write to an access word that carries a start flag, the direction, both addresses and the write data. While the frame is on the wire, the start flag reads back as 1. When the frame ends, the flag clears itself. After a read, the same word returns the sixteen data bits and an acknowledge flag.

MDC is divided down from the system clock. MDIO is driven through an output and an output enable, so the pad can be tri-stated. A pull-up on the line is assumed. On a read, the master releases the line for the turnaround and data phases. It records whether the PHY pulled the second turnaround bit low.

Top module: `mdio_master`

## Requirements
- R1: Control word (reg_sel=0): bit 30 is the enable, bits DIV_W-1:0 are the divider, and both read back as written. Bit 31 reads 1 when no frame is running and 0 while one is. All other bits read 0. After reset the word reads 32'h8000_0000.
- R2: Access word (reg_sel=1) layout: bit 31 GO, bit 30 write (1) or read (0), bit 29 ACK, bits 25:21 PHY register, bits 20:16 PHY address, bits 15:0 data. Bits 28:26 read 0. After reset the word reads 0.
- R3: A write of the access word with bit 31 set starts a frame, but only while the enable is 1 and no frame runs. GO then reads 1 until the frame ends and clears itself afterwards. A GO write while disabled leaves GO at 0 and MDC low.
- R4: Writes to the access word while GO is 1 are ignored. The frame on the wire and the fields read back afterwards are those of the first access.
- R5: Each frame is 64 bits, MSB first, in this order: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, 2 turnaround bits (10 on a write), 16 data bits.
- R6: The MDC period is 2*(divider+1) system clocks. MDC is low whenever no frame runs.
- R7: The master changes MDIO only together with a falling MDC edge and samples MDIO on rising edges.
- R8: During a read, the output enable is low for the turnaround and data phases (frame bits 46 to 63) and high before them.
- R9: After a read, ACK is 1 exactly when MDIO was low at the rising edge of the second turnaround bit, and the data field holds the 16 sampled bits. After a write, ACK is 0 and the data field keeps the written value.
- R10: Once a frame ends, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 the access word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO line as seen at the pad |

## Verification
Two situations are the hardest to reach from the ports. The first is a second access that arrives while a frame is already running. The stimulus writes a conflicting access word part-way through a write frame and then checks two things: that the frame on the wire is still the first one, and that the fields read back match the first access. The second is a read where the PHY stays silent. Here a bench PHY model leaves the line to the pull-up during turnaround, so ACK stays 0 and the data reads all ones. The same model answers the other reads with known data, driving it on the falling edges that the master leaves free.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int LAST_BIT = 63;
  localparam int TA_FIRST = 46;
  localparam int TA_LAST  = 47;

  logic             en;
  logic [DIV_W-1:0] div;
  logic             go, wr, ack;
  logic [4:0]       phy, regad;
  logic [15:0]      data;
  logic [DIV_W-1:0] cnt;
  logic [5:0]       bitn;
  logic [63:0]      frame;
  logic             tick, acc_wr, start;
  logic             unused_bits;

  assign unused_bits = ^reg_wdata;
  assign acc_wr = reg_wr && reg_sel && !go;
  assign start  = acc_wr && reg_wdata[31] && en;
  assign tick   = go && (cnt == div);

  assign frame = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, regad,
                  (wr ? 2'b10 : 2'b11), (wr ? data : 16'hFFFF)};

  assign mdio_out = go ? frame[6'd63 - bitn] : 1'b1;
  assign mdio_oe  = go && (wr || bitn < 6'(TA_FIRST));

  assign reg_rdata = reg_sel ? {go, wr, ack, 3'b000, regad, phy, data}
                             : {!go, en, {(30-DIV_W){1'b0}}, div};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      div <= '0;
    end else if (reg_wr && !reg_sel) begin
      en  <= reg_wdata[30];
      div <= reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go    <= 1'b0;
      wr    <= 1'b0;
      ack   <= 1'b0;
      phy   <= '0;
      regad <= '0;
      data  <= '0;
      cnt   <= '0;
      bitn  <= '0;
      mdc   <= 1'b0;
    end else if (acc_wr) begin
      wr    <= reg_wdata[30];
      regad <= reg_wdata[25:21];
      phy   <= reg_wdata[20:16];
      data  <= reg_wdata[15:0];
      ack   <= 1'b0;
      cnt   <= '0;
      bitn  <= '0;
      mdc   <= 1'b0;
      go    <= start;
    end else if (go) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        mdc <= ~mdc;
        if (!mdc) begin
          if (!wr && bitn == 6'(TA_LAST))
            ack <= !mdio_in;
          if (!wr && bitn > 6'(TA_LAST))
            data <= {data[14:0], mdio_in};
        end else if (bitn == 6'(LAST_BIT)) begin
          go <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
        end
      end
    end
  end

  AST_GO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_wdata[31] && en && !go) |=> go); // R3

  AST_GO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && reg_wr && reg_sel) |=> (go || $past(mdc))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> (!mdc && !mdio_oe)); // R10

  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go) && !$fell(mdc)) |-> $stable(mdio_out)); // R7

  AST_ACK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && ack) |-> !wr); // R9

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !en) |=> !go); // R3
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  mdio_master #(.DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_rise = -1;
  int period = 0;
  int rise_n = 0;
  int r7_viol = 0;
  logic [63:0] cap_bits, cap_oe;
  logic        phy_respond = 1'b0;
  logic [15:0] phy_data = '0;
  logic        p_out = 1'b1, p_oe = 1'b0, p_mdc = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    if (last_rise >= 0) period = cyc - last_rise;
    last_rise = cyc;
    if (rise_n < 64) begin
      cap_bits[63-rise_n] = mdio_oe ? mdio_out : 1'b1;
      cap_oe[63-rise_n]   = mdio_oe;
    end
    rise_n++;
    if (rise_n == 64) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: actual unexpected frame expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " R5 frame hi"}, 32'(((cap_bits ^ e.bits) & e.oe) >> 32), 32'h0);
        check({e.tag, " R5 frame lo"}, 32'((cap_bits ^ e.bits) & e.oe), 32'h0);
        check({e.tag, " R8 oe hi"}, cap_oe[63:32], e.oe[63:32]);
        check({e.tag, " R8 oe lo"}, cap_oe[31:0], e.oe[31:0]);
      end
    end
  end

  always @(negedge mdc) begin
    if (rise_n == 47) mdio_in = phy_respond ? 1'b0 : 1'b1;
    else if (rise_n >= 48 && rise_n < 64) mdio_in = phy_respond ? phy_data[63-rise_n] : 1'b1;
    else mdio_in = 1'b1;
  end

  always @(negedge clk) begin
    if (mdio_oe && p_oe && mdio_out !== p_out && !(p_mdc && !mdc)) r7_viol++;
    p_out = mdio_out; p_oe = mdio_oe; p_mdc = mdc;
  end

  task automatic reg_write(input logic sel, input logic [31:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [31:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  function automatic logic [63:0] build_frame(input logic w, input logic [4:0] p,
      input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, 2'b10, d};
  endfunction

  task automatic wait_done();
    logic [31:0] v;
    do reg_read(1'b1, v); while (v[31]);
  endtask

  task automatic access(input string tag, input logic w, input logic [4:0] p,
      input logic [4:0] r, input logic [15:0] d, input logic resp, input logic [15:0] pd);
    exp_t e;
    logic [31:0] v;
    logic [15:0] exp_data;
    e.bits = build_frame(w, p, r, d);
    e.oe   = w ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
    e.tag  = tag;
    exp_q.push_back(e);
    phy_respond = resp; phy_data = pd; rise_n = 0;
    reg_write(1'b1, {1'b1, w, 4'b0000, r, p, d});
    reg_read(1'b1, v);
    check({tag, " R3 go busy"}, 32'(v[31]), 32'h1);
    reg_read(1'b0, v);
    check({tag, " R1 idle low"}, 32'(v[31]), 32'h0);
    wait_done();
    exp_data = w ? d : (resp ? pd : 16'hFFFF);
    reg_read(1'b1, v);
    check({tag, " R2 R9 access"}, v, {1'b0, w, (!w && resp), 3'b000, r, p, exp_data});
    check({tag, " R10 oe"}, 32'(mdio_oe), 32'h0);
    check({tag, " R6 mdc idle"}, 32'(mdc), 32'h0);
    check({tag, " R3 frames"}, 32'(rise_n), 32'd64);
  endtask

  initial begin
    #(8*150000);
    checks++; errors++;
    $display("FAIL R3: watchdog expired actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_read(1'b0, v);
    check("R1 reset ctrl", v, 32'h8000_0000);
    reg_read(1'b1, v);
    check("R2 reset access", v, 32'h0);
    check("R6 reset mdc", 32'(mdc), 32'h0);

    reg_write(1'b0, 32'h4000_0001);
    reg_read(1'b0, v);
    check("R1 ctrl readback", v, 32'hC000_0001);

    access("write", 1'b1, 5'd5, 5'd3, 16'hA5C3, 1'b0, 16'h0);
    check("R6 period div1", 32'(period), 32'd4);

    access("read ack", 1'b0, 5'd5, 5'd17, 16'h0000, 1'b1, 16'h1234);
    access("read noack", 1'b0, 5'd9, 5'd2, 16'h0000, 1'b0, 16'h0);

    reg_write(1'b0, 32'h4000_0003);
    access("read div3", 1'b0, 5'd31, 5'd31, 16'h0000, 1'b1, 16'hFEDC);
    check("R6 period div3", 32'(period), 32'd8);

    begin
      exp_t e;
      e.bits = build_frame(1'b1, 5'd1, 5'd4, 16'h0F0F);
      e.oe = {64{1'b1}};
      e.tag = "busy";
      exp_q.push_back(e);
      phy_respond = 1'b0; rise_n = 0;
      reg_write(1'b1, {1'b1, 1'b1, 4'b0000, 5'd4, 5'd1, 16'h0F0F});
      repeat (50) @(negedge clk);
      reg_write(1'b1, {1'b1, 1'b0, 4'b0000, 5'd9, 5'd7, 16'hBEEF});
      wait_done();
      reg_read(1'b1, v);
      check("R4 fields kept", v, {1'b0, 1'b1, 1'b0, 3'b000, 5'd4, 5'd1, 16'h0F0F});
      check("R4 single frame", 32'(rise_n), 32'd64);
    end

    reg_write(1'b0, 32'h0000_0001);
    rise_n = 0;
    reg_write(1'b1, {1'b1, 1'b0, 4'b0000, 5'd1, 5'd1, 16'h0});
    repeat (20) @(negedge clk);
    reg_read(1'b1, v);
    check("R3 disabled go", 32'(v[31]), 32'h0);
    check("R3 disabled mdc", 32'(rise_n), 32'h0);
    reg_read(1'b0, v);
    check("R1 disabled ctrl", v, 32'h8000_0001);

    check("R7 mdio change timing", 32'(r7_viol), 32'h0);
    check("R5 queue empty", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule